// File: doc/BRIEF.md
# External Bus Master Arbiter

This block hands a 16-bit processor bus over to one external device through a request/grant handshake. The external device pulls an asynchronous active-low request. The block synchronizes the request and waits until no internal bus cycle is in progress. It then turns off the internal address, data, strobe and direction drivers. Only after that does it assert the active-low grant.

While the external device owns the bus, it runs its own cycles with an active-low address strobe. The block ends each legal cycle with an active-low data-transfer acknowledge. Legal cycles are word accesses whose byte address lies below 64M. Any other access gets no acknowledge and sets a sticky error flag, which a clear input resets.

An internal DMA requester shares the bus with the external master in alternate cycles. When the external device removes its request, grant is withdrawn first. The internal drivers come back one clock later.

Top module: `ext_bus_arbiter`

## Requirements
- R1: The internal drivers are never enabled (`drv_oe`=1) while grant is asserted (`grant_n`=0).
- R2: While `cyc_busy` is 1, a pending request leaves `drv_oe`=1 and `grant_n`=1. With `cyc_busy`=0, a request first sampled low at rising edge k clears `drv_oe` after edge k+2.
- R3: `grant_n` falls exactly one clock after `drv_oe` falls. `grant_n` never falls while `drv_oe` is 1.
- R4: While the bus is owned and the cycle is legal and allowed, `dtack_n` goes low after the second rising edge that samples `ext_as_n` low. It returns high after the first rising edge that samples `ext_as_n` high.
- R5: Grant is held while the request stays low. A request first sampled high at edge r raises `grant_n` after edge r+2.
- R6: An access is refused when its byte address has any bit at or above bit 26 set, i.e. the address is 64M or more. A refused access is never acknowledged and sets `err` after the second rising edge that samples the strobe low.
- R7: An access is refused unless both byte strobes `ext_uds_n` and `ext_lds_n` are low. A refused access is never acknowledged and sets `err` the same way.
- R8: While the bus is owned, `dma_gnt` is given only between external cycles. After each acknowledged external cycle, a waiting DMA request is granted one clock after the acknowledge ends. An external cycle is held unacknowledged while `dma_gnt`=1 and while the DMA has its turn. When `dma_req` drops, `dma_gnt` clears on the next edge and the external master has the next turn.
- R9: `drv_oe` returns to 1 one clock after `grant_n` rises.
- R10: `err` stays set until a clock edge with `err_clr`=1.
- R11: After reset: `grant_n`=1, `drv_oe`=1, `dtack_n`=1, `dma_gnt`=0, `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Asynchronous active-low bus request from the external device |
| cyc_busy | input | 1 | An internal bus cycle is in progress |
| dma_req | input | 1 | Internal DMA requests a bus cycle; held until its cycle is done |
| ext_as_n | input | 1 | External address strobe, active low |
| ext_uds_n | input | 1 | External upper byte strobe, active low |
| ext_lds_n | input | 1 | External lower byte strobe, active low |
| ext_addr | input | ADDR_W-1 | External word address (byte address bits ADDR_W-1 down to 1) |
| err_clr | input | 1 | Clears the sticky error flag |
| grant_n | output | 1 | Bus grant, active low |
| drv_oe | output | 1 | Output enable for internal address, data, strobe and direction drivers |
| dtack_n | output | 1 | Data-transfer acknowledge for external cycles, active low |
| dma_gnt | output | 1 | DMA may run one bus cycle |
| err | output | 1 | Sticky flag: a refused external access was seen |

## Verification
Grant timing counts from the edge that first samples the request: driver release is due after edge k+2 and grant after k+3. On removal of the request, grant rises after edge r+2 and the drivers return after r+3. Acknowledge and error are due after the second edge that samples the strobe low. The acknowledge clears one edge after the strobe is seen high. A DMA grant is due one edge after it is allowed. The bench drives every input on a falling edge and counts whole clocks from there, so each check sits on the falling edge right after the rising edge where the result must appear. It also checks the cycle before, where the result must still be absent.

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
  parameter int ADDR_W  = 32,
  parameter int LIM_BIT = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              cyc_busy,
  input  logic              dma_req,
  input  logic              ext_as_n,
  input  logic              ext_uds_n,
  input  logic              ext_lds_n,
  input  logic [ADDR_W-1:1] ext_addr,
  input  logic              err_clr,
  output logic              grant_n,
  output logic              drv_oe,
  output logic              dtack_n,
  output logic              dma_gnt,
  output logic              err
);

  typedef enum logic [1:0] {S_IDLE, S_REL, S_OWN, S_DROP} st_t;

  st_t  state;
  logic req_s1, req_s2;
  logic as_s;
  logic dtack;
  logic turn_dma;

  wire owned     = (state == S_OWN);
  wire keep      = owned & req_s2;
  wire bad       = (|ext_addr[ADDR_W-1:LIM_BIT]) | ext_uds_n | ext_lds_n;
  wire strobe    = as_s & ~ext_as_n;
  wire ext_turn  = ~turn_dma | ~dma_req;
  wire ack_start = strobe & ~bad & ext_turn & ~dma_gnt;

  assign drv_oe  = (state == S_IDLE);
  assign grant_n = ~owned;
  assign dtack_n = ~dtack;

  // request synchronizer
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= ~req_n;
      req_s2 <= req_s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else
      case (state)
        S_IDLE:  if (req_s2 && !cyc_busy) state <= S_REL;
        S_REL:   state <= S_OWN;
        S_OWN:   if (!req_s2) state <= S_DROP;
        default: state <= S_IDLE;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      as_s     <= 1'b0;
      dtack    <= 1'b0;
      turn_dma <= 1'b0;
      dma_gnt  <= 1'b0;
    end else begin
      as_s  <= ~ext_as_n;
      dtack <= keep & strobe & (dtack | ack_start);
      if (!owned) begin
        turn_dma <= 1'b0;
        dma_gnt  <= 1'b0;
      end else if (dma_gnt) begin
        if (!dma_req) begin
          dma_gnt  <= 1'b0;
          turn_dma <= 1'b0;
        end
      end else begin
        if (dtack && ext_as_n) turn_dma <= 1'b1;
        dma_gnt <= keep & dma_req & turn_dma & ~as_s & ext_as_n;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= 1'b0;
    else if (owned && strobe && bad) err <= 1'b1;
    else if (err_clr) err <= 1'b0;

  p_one_master_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_oe && !grant_n));

  p_wait_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_oe && cyc_busy) |=> drv_oe);

  p_release_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(grant_n) |-> $past(!drv_oe));

  p_ack_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dtack_n |-> (!grant_n && $past(!ext_as_n)));

  p_ack_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dtack_n && !ext_as_n) |-> !bad);

  p_dma_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |-> (dtack_n && !grant_n));

  p_reenable_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe) |-> $past(grant_n));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);

endmodule

// File: tb/ext_bus_arbiter_tb.sv
module ext_bus_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1, cyc_busy = 1'b0, dma_req = 1'b0;
  logic ext_as_n = 1'b1, ext_uds_n = 1'b1, ext_lds_n = 1'b1;
  logic [31:1] ext_addr = '0;
  logic err_clr = 1'b0;
  logic grant_n, drv_oe, dtack_n, dma_gnt, err;

  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  ext_bus_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .cyc_busy(cyc_busy),
    .dma_req(dma_req), .ext_as_n(ext_as_n), .ext_uds_n(ext_uds_n),
    .ext_lds_n(ext_lds_n), .ext_addr(ext_addr), .err_clr(err_clr),
    .grant_n(grant_n), .drv_oe(drv_oe), .dtack_n(dtack_n),
    .dma_gnt(dma_gnt), .err(err)
  );

  // {byte address, uds_n, lds_n, expect ack}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {32'h0000_1000, 1'b0, 1'b0, 1'b1},
    {32'h03FF_FFFE, 1'b0, 1'b0, 1'b1},
    {32'h0400_0000, 1'b0, 1'b0, 1'b0},
    {32'h8000_0040, 1'b0, 1'b0, 1'b0},
    {32'h0000_2000, 1'b1, 1'b0, 1'b0},
    {32'h0000_2002, 1'b0, 1'b1, 1'b0}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic ext_cycle(input logic [31:0] a, input logic u, input logic l,
                           input logic ack, input string tag);
    ext_addr = a[31:1]; ext_uds_n = u; ext_lds_n = l; ext_as_n = 1'b0;
    step(1);
    chk({tag, " no early ack R4"}, dtack_n, 1'b1);
    step(1);
    chk({tag, " ack R4/R6/R7"}, dtack_n, !ack);
    chk({tag, " err R6/R7"}, err, !ack);
    ext_as_n = 1'b1;
    step(1);
    chk({tag, " ack off R4"}, dtack_n, 1'b1);
    if (!ack) begin
      chk({tag, " err held R10"}, err, 1'b1);
      err_clr = 1'b1;
      step(1);
      err_clr = 1'b0;
      chk({tag, " err cleared R10"}, err, 1'b0);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("reset grant R11", grant_n, 1'b1);
    chk("reset drv R11", drv_oe, 1'b1);
    chk("reset dtack R11", dtack_n, 1'b1);
    chk("reset dma R11", dma_gnt, 1'b0);
    chk("reset err R11", err, 1'b0);
    rst_n = 1'b1;
    step(2);

    // request during internal cycle
    cyc_busy = 1'b1; req_n = 1'b0;
    step(6);
    chk("busy drv R2", drv_oe, 1'b1);
    chk("busy grant R2", grant_n, 1'b1);
    cyc_busy = 1'b0;
    step(1);
    chk("release drv R2", drv_oe, 1'b0);
    chk("grant not yet R3", grant_n, 1'b1);
    step(1);
    chk("grant R3", grant_n, 1'b0);

    // address / size table
    for (int i = 0; i < NV; i++)
      ext_cycle(VEC[i][34:3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("vec%0d", i));

    // alternation: previous vec0/1 acked, turn belongs to DMA now
    ext_cycle(32'h0000_0100, 1'b0, 1'b0, 1'b1, "pre-dma");
    dma_req = 1'b1;
    step(1);
    chk("dma grant R8", dma_gnt, 1'b1);
    ext_addr = 31'h80; ext_uds_n = 1'b0; ext_lds_n = 1'b0; ext_as_n = 1'b0;
    step(3);
    chk("ext held during dma R8", dtack_n, 1'b1);
    dma_req = 1'b0;
    step(1);
    chk("dma done R8", dma_gnt, 1'b0);
    chk("ack not yet R8", dtack_n, 1'b1);
    step(1);
    chk("ext ack after dma R8", dtack_n, 1'b0);
    ext_as_n = 1'b1; dma_req = 1'b1;
    step(1);
    chk("ack end R4", dtack_n, 1'b1);
    chk("dma waits a clock R8", dma_gnt, 1'b0);
    step(1);
    chk("dma next turn R8", dma_gnt, 1'b1);
    dma_req = 1'b0;
    step(1);
    chk("dma off R8", dma_gnt, 0);
    // external turn first even with DMA waiting
    dma_req = 1'b1; ext_as_n = 1'b0;
    step(2);
    chk("ext turn ack R8", dtack_n, 1'b0);
    chk("no dma during ext R8", dma_gnt, 1'b0);
    ext_as_n = 1'b1;
    step(2);
    chk("dma after ext R8", dma_gnt, 1'b1);
    dma_req = 1'b0;
    step(1);

    // release
    req_n = 1'b1;
    step(2);
    chk("grant held R5", grant_n, 1'b0);
    step(1);
    chk("grant off R5", grant_n, 1'b1);
    chk("drv still off R9", drv_oe, 1'b0);
    step(1);
    chk("drv back R9", drv_oe, 1'b1);

    // idle bus: fast grant
    req_n = 1'b0;
    step(2);
    chk("drv before release R2", drv_oe, 1'b1);
    step(1);
    chk("drv released R2", drv_oe, 1'b0);
    step(1);
    chk("grant again R3", grant_n, 1'b0);
    chk("exclusive R1", drv_oe, 1'b0);
    req_n = 1'b1;
    step(4);
    chk("idle again R1", drv_oe & grant_n, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule